// File: doc/BRIEF.md
# Pipelined Montgomery Modular Multiplier

This block computes the Montgomery product P = A·B·2^-W mod N for an odd W-bit modulus N and operands A, B below N. Operand A is cut into NP equal, contiguous bit slices. Each slice is consumed by its own pipeline cell, and slices are taken from the least significant end. Inside a cell the bit steps form a strict chain, because each step needs the previous partial result. NR carry-save steps are therefore chained combinationally, so that NR bits of A retire in every clock. Partial results travel between cells as a sum/carry pair with no carry propagation. A single binary adder and one conditional subtraction at the end produce the reduced result.

The caller presents A, B and N together with a one-cycle `in_valid` pulse. The result appears with a one-cycle `out_valid` pulse a fixed number of cycles later. A new operation may start every W/(NP·NR) cycles while earlier ones are still in flight. The block has no stall input. Mapping values into the residue domain is the caller's job: it multiplies by 2^(2W) mod N to enter the domain and by 1 to leave it. W must be a multiple of NP, the slice width W/NP must be a multiple of NR, and the slice width must be at least 2.

Top module: `mont_mul`

## Requirements
- R1: For odd N and A, B < N, `out_p` equals A·B·2^-W mod N, where W is the operand width.
- R2: Every result is fully reduced: `out_p` < N, including the edge moduli N = 1 and N = 2^W-1 and the operands A = B = N-1.
- R3: `out_valid` is a single-cycle pulse. It is high exactly W/NR+1 clock edges after the edge that sampled the matching `in_valid`, which is 17 edges at the defaults.
- R4: A new operation may be issued every W/(NP·NR) cycles, which is 4 at the defaults. Operations issued at that rate all complete correctly and in issue order. Issuing faster than that is not allowed.
- R5: While `rst` is held and after it is released, `out_valid` is 0 and `out_p` is 0 until the first result.
- R6: Between results, `out_p` holds the last result unchanged.
- R7: A zero operand (A = 0 or B = 0) gives a result of 0.
- R8: Multiplying A by 2^(2W) mod N gives A·2^W mod N. Multiplying that value by 1 returns A.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Start pulse; A, B, N are sampled with it |
| in_a | input | W | Multiplicand A, less than N |
| in_b | input | W | Multiplier B, less than N |
| in_n | input | W | Odd modulus N |
| out_valid | output | 1 | One-cycle result pulse |
| out_p | output | W | Montgomery product, held between pulses |

## Verification
Several properties are checked on every cycle:
- the running sum/carry value in every busy cell stays below 2N, so the W+2-bit vectors cannot overflow;
- the value entering the final adder is below 2N;
- every delivered product is below its modulus;
- `out_valid` follows `in_valid` by exactly the fixed latency;
- no cell is reloaded before it hands its operation on.

Numeric correctness cannot be shown by a per-cycle property. Only the bench scenarios show it: the random back-to-back stream at the maximum issue rate, the zero and extreme-modulus cases, the residue round trip, and the hold of `out_p` between results.

// File: rtl/mont_pkg.sv
package mont_pkg;

  // Width of a counter that must count 0 .. v-1 (at least one bit).
  function automatic int cnt_bits(input int v);
    return (v > 1) ? $clog2(v) : 1;
  endfunction

endpackage

// File: rtl/mont_cell.sv
// One pipeline cell: retires SW bits of A, NR carry-save steps per clock.
module mont_cell #(
  parameter int W  = 32,
  parameter int SW = 8,
  parameter int NR = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ld,
  input  logic [W+1:0]    s_in,
  input  logic [W+1:0]    c_in,
  input  logic [SW-1:0]   a_sl,
  input  logic [W-1:0]    b,
  input  logic [W-1:0]    n,
  output logic            done,
  output logic [W+1:0]    s_out,
  output logic [W+1:0]    c_out
);
  localparam int II   = SW / NR;
  localparam int CW   = mont_pkg::cnt_bits(II);
  localparam int IW   = $clog2(SW);
  localparam int SUMW = W + 2;

  logic            busy;
  logic [CW-1:0]   cnt;
  logic [SUMW-1:0] s_r, c_r;
  logic [SUMW-1:0] s_t, c_t, add_b, add_n, s1, c1;
  logic [IW-1:0]   idx;

  assign done = busy && (cnt == CW'(II - 1));

  // NR chained carry-save steps: add a_i*B, add N if LSB is odd, halve.
  always_comb begin
    s_t = s_r;
    c_t = c_r;
    for (int j = 0; j < NR; j++) begin
      idx   = IW'(int'(cnt) * NR + j);
      add_b = a_sl[idx] ? {2'b00, b} : '0;
      s1    = s_t ^ c_t ^ add_b;
      c1    = ((s_t & c_t) | (s_t & add_b) | (c_t & add_b)) << 1;
      add_n = s1[0] ? {2'b00, n} : '0;
      s_t   = (s1 ^ c1 ^ add_n) >> 1;
      c_t   = (s1 & c1) | (s1 & add_n) | (c1 & add_n);
    end
  end

  assign s_out = s_t;
  assign c_out = c_t;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
      s_r  <= '0;
      c_r  <= '0;
    end else if (ld) begin
      busy <= 1'b1;
      cnt  <= '0;
      s_r  <= s_in;
      c_r  <= c_in;
    end else if (busy) begin
      s_r <= s_t;
      c_r <= c_t;
      if (done) begin
        busy <= 1'b0;
        cnt  <= '0;
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end

  // R2: the partial value held in a busy cell stays below 2N.
  assert_cell_bound_R2: assert property (@(posedge clk) disable iff (rst)
    busy |-> (({1'b0, s_r} + {1'b0, c_r}) < {2'b00, n, 1'b0}));

  // R4: a cell is loaded only when idle or handing its operation on.
  assert_issue_spacing_R4: assert property (@(posedge clk) disable iff (rst)
    ld |-> (!busy || done));

endmodule

// File: rtl/mont_final.sv
// Carry-propagate add, then one conditional subtraction of N.
module mont_final #(
  parameter int W = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld,
  input  logic [W+1:0]  s_in,
  input  logic [W+1:0]  c_in,
  input  logic [W-1:0]  n_in,
  output logic          out_valid,
  output logic [W-1:0]  out_p
);
  localparam int SUMW = W + 2;

  logic            v1;
  logic [SUMW-1:0] sum_r;
  logic [W-1:0]    n_r;
  logic [SUMW-1:0] diff;

  assign diff = sum_r - {2'b00, n_r};

  always_ff @(posedge clk) begin
    if (rst) begin
      v1        <= 1'b0;
      sum_r     <= '0;
      n_r       <= '0;
      out_valid <= 1'b0;
      out_p     <= '0;
    end else begin
      v1        <= ld;
      out_valid <= v1;
      if (ld) begin
        sum_r <= s_in + c_in;
        n_r   <= n_in;
      end
      if (v1) begin
        out_p <= (sum_r >= {2'b00, n_r}) ? diff[W-1:0] : sum_r[W-1:0];
      end
    end
  end

  // R2: the value reaching the adder output is below 2N.
  assert_sum_bound_R2: assert property (@(posedge clk) disable iff (rst)
    v1 |-> (sum_r < {1'b0, n_r, 1'b0}));

  // R2: the delivered product is below its modulus.
  assert_result_reduced_R2: assert property (@(posedge clk) disable iff (rst)
    v1 |=> (out_p < $past(n_r)));

endmodule

// File: rtl/mont_mul.sv
module mont_mul #(
  parameter int W  = 32,
  parameter int NP = 4,
  parameter int NR = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [W-1:0]  in_a,
  input  logic [W-1:0]  in_b,
  input  logic [W-1:0]  in_n,
  output logic          out_valid,
  output logic [W-1:0]  out_p
);
  localparam int SW   = W / NP;
  localparam int SUMW = W + 2;
  localparam int LAT  = W / NR + 1;

  logic            done_v [NP];
  logic [SUMW-1:0] s_v    [NP];
  logic [SUMW-1:0] c_v    [NP];
  logic [W-1:0]    b_hold [NP];
  logic [W-1:0]    n_hold [NP];

  for (genvar k = 0; k < NP; k++) begin : stg
    localparam int AW = W - k * SW;
    logic            ld;
    logic [AW-1:0]   a_src;
    logic [AW-1:0]   a_hold;
    logic [W-1:0]    b_src, n_src;
    logic [SUMW-1:0] s_src, c_src;

    if (k == 0) begin : g_head
      assign ld    = in_valid;
      assign a_src = in_a;
      assign b_src = in_b;
      assign n_src = in_n;
      assign s_src = '0;
      assign c_src = '0;
    end else begin : g_link
      assign ld    = done_v[k-1];
      assign a_src = stg[k-1].a_hold[AW+SW-1:SW];
      assign b_src = b_hold[k-1];
      assign n_src = n_hold[k-1];
      assign s_src = s_v[k-1];
      assign c_src = c_v[k-1];
    end

    always_ff @(posedge clk) begin
      if (ld) begin
        a_hold    <= a_src;
        b_hold[k] <= b_src;
        n_hold[k] <= n_src;
      end
    end

    mont_cell #(.W(W), .SW(SW), .NR(NR)) u_cell (
      .clk   (clk),
      .rst   (rst),
      .ld    (ld),
      .s_in  (s_src),
      .c_in  (c_src),
      .a_sl  (a_hold[SW-1:0]),
      .b     (b_hold[k]),
      .n     (n_hold[k]),
      .done  (done_v[k]),
      .s_out (s_v[k]),
      .c_out (c_v[k])
    );
  end

  mont_final #(.W(W)) u_final (
    .clk       (clk),
    .rst       (rst),
    .ld        (done_v[NP-1]),
    .s_in      (s_v[NP-1]),
    .c_in      (c_v[NP-1]),
    .n_in      (n_hold[NP-1]),
    .out_valid (out_valid),
    .out_p     (out_p)
  );

  // Issue history used only by the latency checks below.
  logic [LAT-1:0] vpipe;
  always_ff @(posedge clk) begin
    if (rst) vpipe <= '0;
    else     vpipe <= {vpipe[LAT-2:0], in_valid};
  end

  // R3: a result pulse appears exactly LAT edges after its start pulse.
  assert_latency_hit_R3: assert property (@(posedge clk) disable iff (rst)
    vpipe[LAT-1] |=> out_valid);
  assert_latency_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    !vpipe[LAT-1] |=> !out_valid);

endmodule

// File: tb/mont_mul_test.sv
module mont_mul_test;
  localparam int W   = 32;
  localparam int NP  = 4;
  localparam int NR  = 2;
  localparam int II  = W / (NP * NR);
  localparam int LAT = W / NR + 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [W-1:0]  in_a = '0, in_b = '0, in_n = '0;
  logic          out_valid;
  logic [W-1:0]  out_p;

  int unsigned cyc = 0;
  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  logic [W-1:0] exp_val [$];
  int unsigned  exp_cyc [$];
  string        exp_tag [$];
  logic [W-1:0] last_p;

  mont_mul #(.W(W), .NP(NP), .NR(NR)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .in_a(in_a), .in_b(in_b), .in_n(in_n),
    .out_valid(out_valid), .out_p(out_p)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // A*B*2^-W mod N, by halving modulo N W times.
  function automatic logic [W-1:0] ref_mont(input logic [W-1:0] a, b, n);
    logic [63:0] x;
    x = ({32'd0, a} * {32'd0, b}) % {32'd0, n};
    for (int i = 0; i < W; i++)
      x = x[0] ? ((x + {32'd0, n}) >> 1) : (x >> 1);
    return x[W-1:0];
  endfunction

  // v * 2^sh mod N by repeated doubling.
  function automatic logic [W-1:0] shl_mod(input logic [W-1:0] v, n, input int sh);
    logic [63:0] x;
    x = {32'd0, v} % {32'd0, n};
    for (int i = 0; i < sh; i++) x = (x << 1) % {32'd0, n};
    return x[W-1:0];
  endfunction

  task automatic check(input bit ok, input string tg, input logic [W-1:0] act, exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tg, act, exp);
    end
  endtask

  // Called at a negedge; leaves after 'gap' cycles, again at a negedge.
  task automatic issue(input logic [W-1:0] a, b, n, input logic [W-1:0] ev,
                       input string tg, input int gap);
    in_a = a; in_b = b; in_n = n; in_valid = 1'b1;
    exp_val.push_back(ev);
    exp_cyc.push_back(cyc + 1 + LAT);
    exp_tag.push_back(tg);
    @(negedge clk);
    in_valid = 1'b0;
    for (int i = 1; i < gap; i++) @(negedge clk);
  endtask

  task automatic drain();
    while (exp_val.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // Result monitor: value (R1 etc.), timing (R3), order (R4).
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (exp_val.size() == 0) begin
        check(1'b0, "R3 unexpected out_valid", out_p, '0);
      end else begin
        logic [W-1:0] ev;
        int unsigned  ec;
        string        tg;
        ev = exp_val.pop_front();
        ec = exp_cyc.pop_front();
        tg = exp_tag.pop_front();
        check(out_p == ev, tg, out_p, ev);
        check(cyc == ec, "R3 latency cycle", W'(cyc), W'(ec));
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=0", exp_val.size());
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] a, b, n, x, r2;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R5 out_valid in reset", W'(out_valid), '0);
    check(out_p == '0, "R5 out_p in reset", out_p, '0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R5 out_valid after reset", W'(out_valid), '0);
    check(out_p == '0, "R5 out_p after reset", out_p, '0);

    // Directed corners
    n = 32'hC0FF_EE01;
    issue(32'd0, 32'h1234_5678, n, 32'd0, "R7 A zero", LAT + 2);
    issue(32'h0BAD_F00D, 32'd0, n, 32'd0, "R7 B zero", II);
    issue(32'd0, 32'd0, 32'd1, 32'd0, "R2 modulus one", II);
    n = 32'hFFFF_FFFF;
    issue(n - 1, n - 1, n, ref_mont(n - 1, n - 1, n), "R2 max modulus", II);
    issue(32'd2, 32'd1, 32'd3, ref_mont(32'd2, 32'd1, 32'd3), "R1 small modulus", II);
    n = 32'h8000_0001;
    issue(n - 1, 32'd1, n, ref_mont(n - 1, 32'd1, n), "R2 top-bit modulus", II);
    drain();

    // Residue-domain round trip
    n  = 32'hDEAD_BEEF;
    a  = 32'h1357_9BDF % n;
    r2 = shl_mod(32'd1, n, 2 * W);
    x  = shl_mod(a, n, W);
    issue(a, r2, n, x, "R8 into residue", II);
    issue(x, 32'd1, n, a, "R8 out of residue", II);
    drain();

    // Random stream at the maximum issue rate
    for (int t = 0; t < 40; t++) begin
      n = $urandom | 32'd1;
      if (t % 4 == 0) n[W-1] = 1'b1;
      a = $urandom % n;
      b = $urandom % n;
      issue(a, b, n, ref_mont(a, b, n), "R4 back-to-back", II);
    end
    drain();

    // Random operations with irregular gaps
    for (int t = 0; t < 20; t++) begin
      n = ($urandom % 32'hFFFF_FFF0) | 32'd1;
      a = $urandom % n;
      b = $urandom % n;
      issue(a, b, n, ref_mont(a, b, n), "R1 random", II + ($urandom % 9));
    end
    drain();

    // Hold between results
    last_p = out_p;
    repeat (8) @(negedge clk);
    check(out_p == last_p && !out_valid, "R6 output hold", out_p, last_p);

    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule